// File: doc/BRIEF.md
# Pseudo-Random Self-Test Controller with Signature Check

This block wraps a small combinational circuit so that it can test itself. A 3-bit linear-feedback shift register produces a fixed pseudo-random pattern sequence. A 2:1 selector, switched by a test-enable input, sends either those patterns or the normal functional inputs to the circuit. The responses coming back are folded, one word per clock, into a multiple-input signature register.

A one-cycle start pulse seeds the generator and clears the signature. Once seven patterns have been applied and captured, the controller raises done. It also raises error if the compressed signature differs from the expected constant. When the signature matches, the circuit is fault-free with high probability. Dropping test-enable in the middle of a run freezes the test, and the run picks up again where it stopped. The circuit under test sits outside the block: it is fed from `cut_drv`, and its outputs come back on `cut_resp`.

Top module: `bist_selftest_ctrl`

## Requirements
- R1: After reset, done and error are 0. With test_en at 0, cut_drv equals func_in.
- R2: Whenever test_en is 0, cut_drv follows func_in combinationally for any value of func_in.
- R3: In the cycle after a start pulse (with test_en at 1), cut_drv is 3'b111. At each later clock edge with test_en at 1, it steps through 3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011. The new low bit is bit 2 XOR bit 0 of the old value, shifted in from the right.
- R4: While test_en is 1, cut_drv is never 3'b000.
- R5: done rises at the clock edge that captures the seventh response. It is 0 from the cycle after start until then.
- R6: The signature update is sig_next = (sig shifted left by one, 0 in) XOR (POLY if the old top bit is 1) XOR cut_resp, with the signature cleared to 0 by start. error is 0 at done when the signature after seven captures equals EXP_SIG.
- R7: error is 1 at done when that signature differs from EXP_SIG, for example because one response word was corrupted.
- R8: After done, done and error hold their values, and the generator holds 3'b111, until the next start.
- R9: While test_en is 0, the generator, the step count and the signature hold. A run that is paused part-way and then resumed continues the pattern sequence and ends with the same result as an unpaused run.
- R10: A start pulse clears done and error in the next cycle and restarts the sequence, even after a completed or failed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that seeds the generator and clears the signature |
| test_en | input | 1 | 1: patterns drive the circuit and the test advances; 0: functional inputs, test frozen |
| func_in | input | PAT_W | Functional inputs for the circuit under test |
| cut_resp | input | OUT_W | Response word from the circuit under test |
| cut_drv | output | PAT_W | Inputs applied to the circuit under test |
| done | output | 1 | Test sequence finished |
| error | output | 1 | Signature mismatch, valid while done is 1 |

## Verification
The bench uses the default 3-bit generator, a 4-bit signature with POLY 4'b0011, and seven patterns. It passes in an EXP_SIG that it computes itself from its own model of the circuit, and that model is a multiply-and-XOR function of the pattern. With these values, every step of the full maximal sequence and the wrap back to the seed can be observed at the ports. A single injected response error is enough to produce a mismatch, because the feedback polynomial has a constant term. The bench also runs a test paused mid-sequence, with the functional inputs changing during the pause.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int CNT_W = 8;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
    } seq_state_t;

endpackage

// File: rtl/bist_patgen.sv
module bist_patgen #(
    parameter int             W    = 3,
    parameter logic [W-1:0]   SEED = '1,
    parameter logic [W-1:0]   TAPS = 3'b101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] pat
);

    logic [W-1:0] pat_d, pat_q;

    always_comb begin
        pat_d = pat_q;
        if (load) begin
            pat_d = SEED;
        end else if (step) begin
            pat_d = {pat_q[W-2:0], ^(pat_q & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= SEED;
        end else begin
            pat_q <= pat_d;
        end
    end

    assign pat = pat_q;

endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
    parameter int           W    = 4,
    parameter logic [W-1:0] POLY = 4'b0011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig_next
);

    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_next = {sig_q[W-2:0], 1'b0} ^ ({W{sig_q[W-1]}} & POLY) ^ resp;
        sig_d    = sig_q;
        if (clear) begin
            sig_d = '0;
        end else if (step) begin
            sig_d = sig_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else begin
            sig_q <= sig_d;
        end
    end

endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter int           N_PAT   = 7,
    parameter int           W       = 4,
    parameter logic [W-1:0] EXP_SIG = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         test_en,
    input  logic [W-1:0] sig_next,
    output logic         step,
    output logic         busy,
    output logic         done,
    output logic         error
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_PAT - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = st_q.busy && test_en && !start;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.done = 1'b0;
            st_d.err  = 1'b0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.err  = (sig_next != EXP_SIG);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign error = st_q.err;

endmodule

// File: rtl/bist_selftest_ctrl.sv
module bist_selftest_ctrl #(
    parameter int               PAT_W   = 3,
    parameter int               OUT_W   = 4,
    parameter int               N_PAT   = 7,
    parameter logic [PAT_W-1:0] SEED    = 3'b111,
    parameter logic [PAT_W-1:0] TAPS    = 3'b101,
    parameter logic [OUT_W-1:0] POLY    = 4'b0011,
    parameter logic [OUT_W-1:0] EXP_SIG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             test_en,
    input  logic [PAT_W-1:0] func_in,
    input  logic [OUT_W-1:0] cut_resp,
    output logic [PAT_W-1:0] cut_drv,
    output logic             done,
    output logic             error
);

    logic             step;
    logic             busy;
    logic [PAT_W-1:0] pat_q;
    logic [OUT_W-1:0] sig_next;

    bist_patgen #(.W(PAT_W), .SEED(SEED), .TAPS(TAPS)) u_patgen (
        .clk  (clk),
        .rst_n(rst_n),
        .load (start),
        .step (step),
        .pat  (pat_q)
    );

    bist_misr #(.W(OUT_W), .POLY(POLY)) u_misr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .step    (step),
        .resp    (cut_resp),
        .sig_next(sig_next)
    );

    bist_seq #(.N_PAT(N_PAT), .W(OUT_W), .EXP_SIG(EXP_SIG)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .test_en (test_en),
        .sig_next(sig_next),
        .step    (step),
        .busy    (busy),
        .done    (done),
        .error   (error)
    );

    assign cut_drv = test_en ? pat_q : func_in;

endmodule

// File: rtl/bist_selftest_ctrl_chk.sv
module bist_selftest_ctrl_chk #(
    parameter int PAT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             test_en,
    input logic [PAT_W-1:0] cut_drv,
    input logic [PAT_W-1:0] pat_q,
    input logic             busy,
    input logic             done,
    input logic             error
);

    // R4
    drv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |-> cut_drv != '0);

    // R3
    pat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && test_en && !start) |=> pat_q != $past(pat_q));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(error) && $stable(pat_q)));

    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && !start) |=> ($stable(pat_q) && $stable(busy) && $stable(done)));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !error && busy));

    // R5
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (done || busy));

endmodule

bind bist_selftest_ctrl bist_selftest_ctrl_chk #(.PAT_W(PAT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .test_en(test_en),
    .cut_drv(cut_drv),
    .pat_q  (pat_q),
    .busy   (busy),
    .done   (done),
    .error  (error)
);

// File: tb/bist_selftest_ctrl_tb.sv
module bist_selftest_ctrl_tb;

    localparam int         PW   = 3;
    localparam int         OW   = 4;
    localparam logic [3:0] POLY = 4'b0011;
    localparam int         MULT = 5;

    function automatic logic [OW-1:0] cut_fn(input logic [PW-1:0] x);
        logic [7:0] prod;
        prod = 8'(x) * 8'(MULT);
        return prod[OW-1:0] ^ {1'b0, x};
    endfunction

    function automatic logic [PW-1:0] seq_at(input int k);
        case (k)
            0: return 3'b111;
            1: return 3'b110;
            2: return 3'b101;
            3: return 3'b010;
            4: return 3'b100;
            5: return 3'b001;
            default: return 3'b011;
        endcase
    endfunction

    function automatic logic [OW-1:0] golden_sig();
        logic [OW-1:0] s;
        s = '0;
        for (int k = 0; k < 7; k++) begin
            s = {s[OW-2:0], 1'b0} ^ (s[OW-1] ? POLY : '0) ^ cut_fn(seq_at(k));
        end
        return s;
    endfunction

    localparam logic [OW-1:0] GOLD = golden_sig();

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          test_en = 1'b0;
    logic [PW-1:0] func_in = 3'd5;
    logic [OW-1:0] cut_resp;
    logic [PW-1:0] cut_drv;
    logic          done, error;
    logic          fault_on = 1'b0;

    always #5 clk = ~clk;

    assign cut_resp = cut_fn(cut_drv) ^ ((fault_on && cut_drv == 3'b010) ? 4'b0100 : 4'b0000);

    bist_selftest_ctrl #(.POLY(POLY), .EXP_SIG(GOLD)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .test_en (test_en),
        .func_in (func_in),
        .cut_resp(cut_resp),
        .cut_drv (cut_drv),
        .done    (done),
        .error   (error)
    );

    typedef struct {
        logic [PW-1:0] drv;
        bit            chk_flags;
        logic          dn;
        logic          er;
        string         tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;

    task automatic push(input logic [PW-1:0] d, input bit cf, input logic dn,
                        input logic er, input string tag);
        item_t it;
        it.drv = d; it.chk_flags = cf; it.dn = dn; it.er = er; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares outputs 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (cut_drv !== it.drv) begin
                    failures++;
                    $display("FAIL %s cut_drv actual=%b expected=%b", it.tag, cut_drv, it.drv);
                end
                if (it.chk_flags) begin
                    checks++;
                    if (done !== it.dn || error !== it.er) begin
                        failures++;
                        $display("FAIL %s done/error actual=%b%b expected=%b%b",
                                 it.tag, done, error, it.dn, it.er);
                    end
                end
            end
        end
    end

    task automatic run_test(input bit fault, input int pause_at, input string tag_end);
        @(negedge clk);
        fault_on = fault;
        start = 1'b1; test_en = 1'b1;
        for (int k = 0; k < 7; k++) begin
            if (k == pause_at) begin
                for (int p = 0; p < 3; p++) begin
                    @(negedge clk);
                    start = 1'b0; test_en = 1'b0; func_in = 3'(p + 2);
                    push(func_in, 1, 1'b0, 1'b0, "R9 pause");
                end
            end
            @(negedge clk);
            start = 1'b0; test_en = 1'b1;
            push(seq_at(k), 1, 1'b0, 1'b0, (k == 0) ? "R10 restart" : "R3 R4 R5 step");
        end
        @(negedge clk);
        push(3'b111, 1, 1'b1, fault, tag_end);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            test_en = h[0];
            func_in = 3'(h + 4);
            push(test_en ? 3'b111 : func_in, 1, 1'b1, fault, "R8 hold");
        end
    endtask

    initial begin
        test_en = 1'b0; func_in = 3'd5;
        #1;
        push(3'd5, 1, 1'b0, 1'b0, "R1 reset");
        #30;
        @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            func_in = 3'(v);
            push(3'(v), 1, 1'b0, 1'b0, "R2 functional path");
        end
        run_test(1'b0, -1, "R5 R6 pass");
        run_test(1'b1, -1, "R7 mismatch");
        run_test(1'b0, 3, "R9 R6 resumed pass");
        run_test(1'b0, 0, "R10 R9 pause at first");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule